// File: doc/BRIEF.md
# Prioritized Vectored Port Interrupt Merger

This block combines four handshake status sources, numbered H1 to H4, into a single interrupt request. Each source has a sticky status bit, which the handshake logic outside this block sets with a one-cycle pulse. Software clears these bits by writing a mask. An interrupt is raised when a status bit is set and its enable is on. H1 and H3 can also be tied to a DMA channel. While a source is tied to DMA, it takes no part in the request and no part in the vector.

When the processor acknowledges the interrupt, the block drives an 8-bit vector. The top six bits come from a programmable base register. The low two bits name the winning source. If the base register has not been written since reset, the vector is the fixed value 0x0F. If no source qualifies, the block does not drive the bus at all.

An acknowledge cycle changes no status bit and no register. The vector is fixed at the start of the acknowledge and does not change while acknowledge stays high.

Register writes are selected by `reg_addr`:
- Address 0 loads the vector base from `reg_wdata[7:2]`.
- Address 1 holds the control register. Bits [3:0] are the enables for H1 to H4, in that order. Bit 4 ties H1 to DMA and bit 5 ties H3 to DMA.
- Address 2 is the clear mask. A 1 in bit k of `reg_wdata[3:0]` clears the status bit of source k+1.
- Address 3 has no effect.

Top module: `vport_irq_merge`

## Requirements
- R1: After reset, `status_o` = 0, `irq_o` = 0 and `vec_oe` = 0. The enables, the DMA ties and the vector base are all 0, and the base counts as not written.
- R2: A 1 on `stat_set[k]` sets `status_o[k]` from the next clock edge on. The bit stays set until it is cleared. If a set and a clear hit the same bit in the same cycle, the set wins.
- R3: A write to address 2 clears every status bit whose mask bit is 1 and leaves the bits whose mask bit is 0 unchanged.
- R4: `irq_o` is 1 exactly when some source k has its status bit set and its enable (control bit k) set, and is not tied to DMA. Only H1 (control bit 4) and H3 (control bit 5) can be tied to DMA.
- R5: Among the qualifying sources, priority runs from H1 (highest) to H4 (lowest). The winner is encoded in `vec_o[1:0]` as H1=00, H2=01, H3=10, H4=11.
- R6: After any write to address 0, an acknowledge returns `{base[7:2], code}`, where `base` is the data of the most recent address-0 write.
- R7: If address 0 has not been written since reset, an acknowledge with a qualifying source returns 0x0F.
- R8: When `iack` is low, or when it rises with no qualifying source, `vec_oe` is 0 and `vec_o` is 0.
- R9: Acknowledge cycles leave `status_o`, `irq_o` and all register contents unchanged.
- R10: While `iack` stays high, `vec_o` and `vec_oe` keep the values they had in the first cycle of the acknowledge, even if sources change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_set | input | 4 | Status set pulses for H1..H4 (bit 0 = H1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 control, 2 clear mask |
| reg_wdata | input | 8 | Register write data |
| iack | input | 1 | Interrupt acknowledge |
| status_o | output | 4 | Status bits H1..H4 |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector, valid while vec_oe is 1 |
| vec_oe | output | 1 | Vector drive enable |

## Verification
A status bit that is stuck or missing shows up on `status_o` and `irq_o` one cycle after the pulse or the clear write that should have changed it. A wrong enable, DMA tie or priority decode appears combinationally: `irq_o` and the low two vector bits go wrong in the very next acknowledge. A lost "base written" flag, or a held vector that is not latched correctly, shows only during an acknowledge. The fallback value appears where the programmed base was expected, or the vector moves between two cycles of the same acknowledge.

// File: rtl/vport_irq_merge.sv
module vport_irq_merge #(
  parameter logic [7:0] FALLBACK_VEC = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] stat_set,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       iack,
  output logic [3:0] status_o,
  output logic       irq_o,
  output logic [7:0] vec_o,
  output logic       vec_oe
);
  localparam logic [1:0] A_BASE = 2'd0, A_CTRL = 2'd1, A_CLR = 2'd2;

  logic [3:0] stat_q, en_q;
  logic       dma1_q, dma3_q, vinit_q, ack_q, held_oe_q;
  logic [5:0] vbase_q;
  logic [7:0] held_vec_q;
  logic [1:0] code;
  logic [3:0] qual, clr;
  logic [7:0] live_vec;
  logic       use_held;

  assign clr  = (reg_we && reg_addr == A_CLR) ? reg_wdata[3:0] : 4'b0;
  assign qual = stat_q & en_q & ~{1'b0, dma3_q, 1'b0, dma1_q};

  always_comb begin
    code = 2'd3;
    if      (qual[0]) code = 2'd0;
    else if (qual[1]) code = 2'd1;
    else if (qual[2]) code = 2'd2;
  end

  assign live_vec = vinit_q ? {vbase_q, code} : FALLBACK_VEC;
  assign use_held = iack & ack_q;
  assign irq_o    = |qual;
  assign status_o = stat_q;
  assign vec_oe   = iack & (use_held ? held_oe_q : irq_o);
  assign vec_o    = !vec_oe ? 8'h00 : (use_held ? held_vec_q : live_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      en_q       <= '0;
      dma1_q     <= 1'b0;
      dma3_q     <= 1'b0;
      vbase_q    <= '0;
      vinit_q    <= 1'b0;
      ack_q      <= 1'b0;
      held_oe_q  <= 1'b0;
      held_vec_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | stat_set;
      if (reg_we && reg_addr == A_BASE) begin
        vbase_q <= reg_wdata[7:2];
        vinit_q <= 1'b1;
      end
      if (reg_we && reg_addr == A_CTRL) begin
        en_q   <= reg_wdata[3:0];
        dma1_q <= reg_wdata[4];
        dma3_q <= reg_wdata[5];
      end
      ack_q <= iack;
      if (iack && !ack_q) begin
        held_oe_q  <= irq_o;
        held_vec_q <= live_vec;
      end
    end
  end
endmodule

// File: rtl/vport_irq_merge_chk.sv
module vport_irq_merge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] stat_set,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       iack,
  input logic [3:0] status_o,
  input logic       irq_o,
  input logic [7:0] vec_o,
  input logic       vec_oe,
  input logic       vinit_q
);
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_set) |=> ((status_o & $past(stat_set)) == $past(stat_set)));

  a_r3_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && stat_set == 4'b0) |=> ((status_o & $past(reg_wdata[3:0])) == 4'b0));

  a_r4_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != 4'b0));

  a_r7_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && !vinit_q) |-> (vec_o == 8'h0F));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |-> (!vec_oe && vec_o == 8'h00));

  a_r9_ack_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && stat_set == 4'b0 && !reg_we) |=> $stable(status_o));

  a_r10_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && $past(iack)) |-> ($stable(vec_o) && $stable(vec_oe)));
endmodule

bind vport_irq_merge vport_irq_merge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .stat_set(stat_set), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .iack(iack),
  .status_o(status_o), .irq_o(irq_o), .vec_o(vec_o), .vec_oe(vec_oe),
  .vinit_q(vinit_q)
);

// File: tb/vport_irq_merge_tb_top.sv
module vport_irq_merge_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] stat_set = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       iack = 1'b0;
  logic [3:0] status_o;
  logic       irq_o, vec_oe;
  logic [7:0] vec_o;

  always #2.5 clk = ~clk;

  vport_irq_merge dut_i (
    .clk(clk), .rst_n(rst_n), .stat_set(stat_set), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .iack(iack),
    .status_o(status_o), .irq_o(irq_o), .vec_o(vec_o), .vec_oe(vec_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] m_st, m_en;
  logic       m_d1, m_d3, m_vi, m_ackp, m_hoe;
  logic [5:0] m_base;
  logic [7:0] m_hvec;

  function automatic logic [3:0] f_qual();
    return m_st & m_en & ~{1'b0, m_d3, 1'b0, m_d1};
  endfunction

  function automatic logic [7:0] f_live();
    logic [3:0] q = f_qual();
    logic [1:0] c = q[0] ? 2'd0 : q[1] ? 2'd1 : q[2] ? 2'd2 : 2'd3;
    return m_vi ? {m_base, c} : 8'h0F;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_en = 0; m_d1 = 0; m_d3 = 0; m_vi = 0; m_base = 0;
    m_ackp = 0; m_hoe = 0; m_hvec = 0;
  endtask

  task automatic step(input string tag);
    logic       e_oe;
    logic [7:0] e_vec;
    #1;
    chk({4'b0, status_o}, {4'b0, m_st}, {tag, " R2/R3/R9 status"});
    chk({7'b0, irq_o}, {7'b0, |f_qual()}, {tag, " R4 irq"});
    if (iack && m_ackp) begin e_oe = m_hoe; e_vec = m_hvec; end
    else begin e_oe = iack & (|f_qual()); e_vec = f_live(); end
    if (!e_oe) e_vec = 8'h00;
    chk({7'b0, vec_oe}, {7'b0, e_oe}, {tag, " R8/R10 vec_oe"});
    chk(vec_o, e_vec, {tag, " R5/R6/R7/R10 vec"});
    @(posedge clk);
    if (iack && !m_ackp) begin m_hoe = |f_qual(); m_hvec = f_live(); end
    m_ackp = iack;
    if (reg_we && reg_addr == 2'd2) m_st = m_st & ~reg_wdata[3:0];
    m_st = m_st | stat_set;
    if (reg_we && reg_addr == 2'd0) begin m_base = reg_wdata[7:2]; m_vi = 1; end
    if (reg_we && reg_addr == 2'd1) begin
      m_en = reg_wdata[3:0]; m_d1 = reg_wdata[4]; m_d3 = reg_wdata[5];
    end
    @(negedge clk);
    stat_set = 0; reg_we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({4'b0, status_o}, 8'h00, "R1 status");
    chk({7'b0, irq_o}, 8'h00, "R1 irq");
    step("R1");
    // R7 fallback before base written
    stat_set = 4'b0010; step("R2 set H2");
    wr(2'd1, 8'h0F, "R4 enable all");
    iack = 1; step("R7 fallback");
    iack = 0; step("R8 after ack");
    // R6 programmed base
    wr(2'd0, 8'hA4, "R6 base");
    iack = 1; step("R6 vec H2");
    // R10: higher priority H1 arrives while ack held
    stat_set = 4'b0001; step("R10 hold");
    step("R10 hold2");
    iack = 0; step("R9 release");
    // R5 priority with R4 DMA tie of H1
    wr(2'd1, 8'h1F, "R4 dma H1");
    iack = 1; step("R4/R5 H1 excluded");
    iack = 0; step("gap");
    // R3 clear mask: clear H2 only, keep H1
    wr(2'd2, 8'h02, "R3 clear H2");
    iack = 1; step("R8 nothing qualifies");
    iack = 0;
    // R2 set beats clear
    stat_set = 4'b1000; reg_we = 1; reg_addr = 2'd2; reg_wdata = 8'h08;
    step("R2 set wins");
    wr(2'd1, 8'h3C, "R4 dma H3");
    stat_set = 4'b0100; step("R4 H3 tied");
    iack = 1; step("R5 H4 code 11");
    iack = 0; step("gap");
    wr(2'd3, 8'hFF, "addr3 ignored");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      stat_set = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
      if ($urandom % 5 == 0) begin
        reg_we = 1; reg_addr = 2'($urandom); reg_wdata = 8'($urandom);
      end
      if ($urandom % 3 == 0) iack = ~iack;
      step("rand R2-R10");
    end
    iack = 0; step("end");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule